// File: doc/BRIEF.md
# Cascadable Priority Encoder

This block turns a set of active-low request lines into the active-low binary index of the most important pending request. A higher index always means a higher priority. The basic unit is an eight-request cell. Each cell has an active-low enable input. It drives an active-low group flag when it has a pending request. It also drives an enable output that goes low only when the cell is enabled and sees no request. That output feeds the enable of the next cell down, so a lower cell can only answer while every cell above it is idle.

The top level chains a parameterised number of cells, two by default, into a wider encoder of sixteen requests. The low code bits are the AND of every cell's active-low code. The upper code bits give the index of the one cell that reports a request, and they come from the cells' group flags. The block is purely combinational. Results follow the inputs in the same cycle, and every input pattern is legal, so there is no handshake at its edge.

Top module: `prio_enc_cascade`

## Requirements
- R1: With enable low, the code reports the highest-numbered asserted request; lower asserted requests have no effect on it.
- R2: The code is active-low. With enable low, request 15 alone gives code 0000, request 0 alone gives 1111, and request 14 alone gives 0001.
- R3: With en_n high, the outputs are code_n = all ones, grp_n = 1 and eo = 1, whatever the requests are.
- R4: With en_n low and no request asserted, the outputs are code_n = all ones, grp_n = 1 and eo = 0.
- R5: With en_n low and at least one request asserted, the outputs are grp_n = 0 and eo = 1.
- R6: A request in the upper half (bits 15..8) disables the lower cell. Any pattern in bits 7..0 then leaves the code unchanged.
- R7: Code bit 3 is low exactly when the winning request lies in bits 15..8. Request 8 gives 0111 and request 7 gives 1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | 16 | Active-low request lines; bit 15 has the highest priority |
| en_n | input | 1 | Active-low enable of the whole encoder |
| code_n | output | 4 | Active-low index of the winning request |
| grp_n | output | 1 | Low when enabled and some request is asserted |
| eo | output | 1 | Low only when enabled and no request is asserted; drives a lower encoder's enable |

## Verification
The checker assumes that every input bit is a known 0 or 1. It evaluates nothing while any request or enable bit is unknown. The bench drives only fully defined patterns, starting before its first check. Every check is made half a clock period after the inputs change, which leaves the combinational paths time to settle. The patterns cover both halves exhaustively, each with the other half idle, plus pseudo-random sixteen-bit words with random enable values.

// File: rtl/pe_pkg.sv
package pe_pkg;
  // Position of the most significant set bit; 0 when none is set.
  function automatic int unsigned top_set(input logic [31:0] v);
    int unsigned idx;
    idx = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction
endpackage

// File: rtl/pe_cell.sv
module pe_cell #(
  parameter int unsigned W = 8,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic [W-1:0]  in_n,
  input  logic          ei_n,
  output logic [CW-1:0] a_n,
  output logic          gs_n,
  output logic          eo
);
  logic [W-1:0] act;
  logic         hit;

  always_comb begin
    act  = ~in_n;
    hit  = |act;
    a_n  = '1;
    gs_n = 1'b1;
    eo   = 1'b1;
    if (!ei_n) begin
      if (hit) begin
        a_n  = ~CW'(pe_pkg::top_set(32'(act)));
        gs_n = 1'b0;
      end else begin
        eo = 1'b0;
      end
    end
  end
endmodule

// File: rtl/pe_merge.sv
module pe_merge #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LOW_W  = 3,
  localparam int unsigned SEL_W = $clog2(STAGES)
) (
  input  logic [STAGES*LOW_W-1:0] cell_code_n,
  input  logic [STAGES-1:0]       cell_gs_n,
  output logic [SEL_W+LOW_W-1:0]  code_n,
  output logic                    grp_n
);
  logic [LOW_W-1:0] low_n;
  logic [SEL_W-1:0] sel_n;

  always_comb begin
    low_n = '1;
    for (int s = 0; s < int'(STAGES); s++) begin
      low_n = low_n & cell_code_n[s*LOW_W +: LOW_W];
    end
  end

  // Only one cell can report at a time, so its index forms the upper bits.
  always_comb begin
    sel_n = '1;
    for (int b = 0; b < int'(SEL_W); b++) begin
      for (int s = 0; s < int'(STAGES); s++) begin
        if (((s >> b) & 1) == 1) sel_n[b] = sel_n[b] & cell_gs_n[s];
      end
    end
  end

  assign code_n = {sel_n, low_n};
  assign grp_n  = &cell_gs_n;
endmodule

// File: rtl/prio_enc_cascade.sv
// STAGES must be a power of two and at least 2.
module prio_enc_cascade #(
  parameter int unsigned STAGE_W = 8,
  parameter int unsigned STAGES  = 2,
  localparam int unsigned REQ_W  = STAGE_W * STAGES,
  localparam int unsigned LOW_W  = $clog2(STAGE_W),
  localparam int unsigned SEL_W  = $clog2(STAGES),
  localparam int unsigned CODE_W = LOW_W + SEL_W
) (
  input  logic [REQ_W-1:0]  req_n,
  input  logic              en_n,
  output logic [CODE_W-1:0] code_n,
  output logic              grp_n,
  output logic              eo
);
  logic [STAGES:0]         chain_n;
  logic [STAGES*LOW_W-1:0] cell_code_n;
  logic [STAGES-1:0]       cell_gs_n;

  assign chain_n[STAGES] = en_n;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_cell
      pe_cell #(.W(STAGE_W)) u_cell (
        .in_n (req_n[s*STAGE_W +: STAGE_W]),
        .ei_n (chain_n[s+1]),
        .a_n  (cell_code_n[s*LOW_W +: LOW_W]),
        .gs_n (cell_gs_n[s]),
        .eo   (chain_n[s])
      );
    end
  endgenerate

  pe_merge #(.STAGES(STAGES), .LOW_W(LOW_W)) u_merge (
    .cell_code_n (cell_code_n),
    .cell_gs_n   (cell_gs_n),
    .code_n      (code_n),
    .grp_n       (grp_n)
  );

  assign eo = chain_n[0];
endmodule

// File: rtl/prio_enc_checker.sv
module prio_enc_checker #(
  parameter int unsigned REQ_W  = 16,
  parameter int unsigned CODE_W = 4
) (
  input logic [REQ_W-1:0]  req_n,
  input logic              en_n,
  input logic [CODE_W-1:0] code_n,
  input logic              grp_n,
  input logic              eo
);
  logic [REQ_W-1:0]  act;
  logic [CODE_W-1:0] want_n;

  always_comb begin
    act    = ~req_n;
    want_n = ~CODE_W'(pe_pkg::top_set(32'(act)));
    if (!$isunknown({req_n, en_n})) begin
      if (en_n) begin
        p_disabled_r3: assert (code_n == '1 && grp_n && eo)
          else $error("R3 disabled outputs wrong");
      end else if (act == '0) begin
        p_idle_r4: assert (code_n == '1 && grp_n && !eo)
          else $error("R4 idle outputs wrong");
      end else begin
        p_active_r5: assert (!grp_n && eo)
          else $error("R5 active flags wrong");
        p_winner_r1: assert (code_n == want_n)
          else $error("R1 winner code wrong");
        p_upper_msb_r7: assert (code_n[CODE_W-1] == ~|act[REQ_W-1:REQ_W/2])
          else $error("R7 code msb wrong");
      end
    end
  end
endmodule

bind prio_enc_cascade prio_enc_checker #(.REQ_W(REQ_W), .CODE_W(CODE_W)) u_chk (
  .req_n  (req_n),
  .en_n   (en_n),
  .code_n (code_n),
  .grp_n  (grp_n),
  .eo     (eo)
);

// File: tb/prio_enc_cascade_bench.sv
module prio_enc_cascade_bench;
  logic        clk = 1'b0;
  logic [15:0] req_n;
  logic        en_n;
  logic [3:0]  code_n;
  logic        grp_n;
  logic        eo;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  prio_enc_cascade u_prio_enc_cascade (
    .req_n  (req_n),
    .en_n   (en_n),
    .code_n (code_n),
    .grp_n  (grp_n),
    .eo     (eo)
  );

  // {req_n, en_n, code_n, grp_n, eo}
  localparam logic [22:0] VEC [12] = '{
    {16'hFFFF, 1'b0, 4'hF, 1'b1, 1'b0},
    {16'h7FFF, 1'b0, 4'h0, 1'b0, 1'b1},
    {16'hFFFE, 1'b0, 4'hF, 1'b0, 1'b1},
    {16'h0000, 1'b1, 4'hF, 1'b1, 1'b1},
    {16'h0000, 1'b0, 4'h0, 1'b0, 1'b1},
    {16'hFEFF, 1'b0, 4'h7, 1'b0, 1'b1},
    {16'hFF7F, 1'b0, 4'h8, 1'b0, 1'b1},
    {16'hEF00, 1'b0, 4'h3, 1'b0, 1'b1},
    {16'hFFF5, 1'b0, 4'hC, 1'b0, 1'b1},
    {16'hFFFE, 1'b1, 4'hF, 1'b1, 1'b1},
    {16'hBFFF, 1'b0, 4'h1, 1'b0, 1'b1},
    {16'hFDFB, 1'b0, 4'h6, 1'b0, 1'b1}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R4";
      1, 2, 10: return "R2";
      3, 9: return "R3";
      5, 6, 11: return "R7";
      7: return "R6";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [5:0] model(input logic [15:0] r_n, input logic e_n);
    logic [15:0] a;
    logic [3:0]  idx;
    a = ~r_n;
    idx = 4'd0;
    if (e_n) return {4'hF, 1'b1, 1'b1};
    if (a == 16'h0) return {4'hF, 1'b1, 1'b0};
    for (int i = 0; i < 16; i++) if (a[i]) idx = 4'(i);
    return {~idx, 1'b0, 1'b1};
  endfunction

  task automatic check(input string tag, input logic [5:0] exp);
    checks++;
    if ({code_n, grp_n, eo} !== exp) begin
      errors++;
      $display("FAIL %s req_n=%h en_n=%b actual code_n=%h grp_n=%b eo=%b expected code_n=%h grp_n=%b eo=%b",
               tag, req_n, en_n, code_n, grp_n, eo, exp[5:2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(input logic [15:0] r, input logic e);
    @(negedge clk);
    req_n = r;
    en_n  = e;
    @(posedge clk);
  endtask

  initial begin
    req_n = 16'hFFFF;
    en_n  = 1'b1;
    @(posedge clk);
    check("R3", 6'b1111_1_1);

    for (int i = 0; i < 12; i++) begin
      apply(VEC[i][22:7], VEC[i][6]);
      check(vec_tag(i), VEC[i][5:0]);
    end

    // R1 R2 R4 R5: every lower-half pattern with upper cell idle
    for (int p = 0; p < 256; p++) begin
      apply({8'hFF, 8'(p)}, 1'b0);
      check("R1", model(req_n, 1'b0));
    end
    // R7: every upper-half pattern with lower cell idle
    for (int p = 0; p < 256; p++) begin
      apply({8'(p), 8'hFF}, 1'b0);
      check("R7", model(req_n, 1'b0));
    end
    // R6: lower half has no say while the upper half requests
    for (int p = 0; p < 64; p++) begin
      apply({8'hDF, 8'(p * 4)}, 1'b0);
      check("R6", {4'h2, 1'b0, 1'b1});
    end
    // R3: disable dominates any pattern
    for (int p = 0; p < 64; p++) begin
      apply(16'($urandom), 1'b1);
      check("R3", 6'b1111_1_1);
    end
    // R5: random words with random enable against the model
    for (int p = 0; p < 2000; p++) begin
      apply(16'($urandom), 1'($urandom));
      check("R5", model(req_n, en_n));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule